// File: doc/BRIEF.md
# Set-Associative Instruction Translation Buffer

This block turns instruction fetch addresses into physical addresses. It uses a small table with a parameter-set number of sets and ways. Each entry pairs two words:

- A tag word holds a page number, a valid bit and a short usage counter.
- A translation word holds a physical page number, a cache-inhibit flag and two execute-permission flags, one for supervisor mode and one for user mode.

Software loads and inspects the table through a word-wide register port. The fetch side hands over one request at a time. After a fixed latency it gets back one of three results:

- a translated address;
- a miss, which the fetch logic hands to its exception path;
- a permission fault.

While translation is switched off, or the unit is strapped as absent, addresses pass through unchanged. Cache-inhibit then follows the top address bit.

A second, purely combinational probe port answers the same question for any address. It never touches the usage counters and never reports an exception. A constant configuration word advertises the table geometry.

Top module: `insn_tlb`

## Requirements
- R1: When `xlateEn` and `present` are not both high, an accepted request returns `rspAddr` equal to the request address. `rspCi` equals the address MSB, so it is high for 0x80000000 and above. `rspHit`, `rspMiss` and `rspFault` are low, and `rspValid` is high in the cycle right after the accepting edge.
- R2: The set is chosen by address bits [PAGE_LOG2 +: log2(SETS)]. A way matches only when tag bit 0 (valid) is set and the tag equals the address on every bit at or above PAGE_LOG2+log2(SETS).
- R3: On a hit, `rspAddr` is the translation word's bits at or above PAGE_LOG2, joined with the request's page-offset bits, and `rspCi` is translation bit 0. `rspValid` comes HIT_LAT edges after the cycle following the accepting edge.
- R4: On a miss, `rspMiss` is high, `rspAddr` is 0 and `rspCi` is 0, and no table entry changes. `rspValid` comes MISS_LAT edges after the cycle following the accepting edge.
- R5: A hit raises `rspFault` together with `rspHit` when execute permission is missing. Permission is translation bit 1 in supervisor mode (`superMode`=1) and translation bit 2 in user mode. `rspAddr` still carries the translation.
- R6: Every hit, faulting or not, updates the tag LRU field (bits [6 +: LRU_W]) of each way in the selected set. A nonzero field drops by one. The hit way's result is then ORed with (SETS-1) truncated to LRU_W bits.
- R7: When several ways of a set match, the lowest-numbered way supplies the translation and takes the LRU reload.
- R8: `probePaddr` applies the R2 match and the R5 permission rule to `probeAddr`. It returns the translated address on a permitted hit and 0 on a miss or a denied hit. It returns `probeAddr` unchanged when translation is off. A probe never changes any entry.
- R9: `cfgWord` has log2(SETS) in bits [6:3], WAYS-1 in bits [1:0], and zero elsewhere.
- R10: `cfgAddr` is {select (1 = translation word, 0 = tag word), way, set}. `cfgRdata` shows the addressed word combinationally. A write lands at the clock edge. A lookup accepted at the same edge sees the old contents. A register write to a tag word overrides that edge's LRU update of the same word.
- R11: After reset every table word reads 0, `reqReady` is high and `rspValid` is low.
- R12: `reqReady` is low from the accepting edge through the response cycle. It is high again in the cycle after `rspValid`, and `rspValid` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| xlateEn | input | 1 | Translation enable |
| present | input | 1 | Unit-present strap |
| superMode | input | 1 | High for supervisor privilege |
| reqValid | input | 1 | Fetch lookup request |
| reqReady | output | 1 | Unit can accept a request |
| reqAddr | input | ADDR_W | Fetch virtual address |
| rspValid | output | 1 | Result valid, one cycle |
| rspAddr | output | ADDR_W | Physical address result |
| rspCi | output | 1 | Cache-inhibit for the fetch |
| rspHit | output | 1 | Table hit |
| rspMiss | output | 1 | Table miss |
| rspFault | output | 1 | Execute permission fault |
| probeAddr | input | ADDR_W | Probe virtual address |
| probePaddr | output | ADDR_W | Probe result, 0 if unusable |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 1+WAY_W+SET_W | {select, way, set} |
| cfgWdata | input | ADDR_W | Register write data |
| cfgRdata | output | ADDR_W | Register read data |
| cfgWord | output | 32 | Geometry word |

## Verification
The bench fills every set and way of a 4-set, 2-way table with distinct page numbers. It then sweeps each entry at the page-offset extremes and in the middle, which shows whether set selection, page matching and offset merging are correct. Passthrough addresses on each side of the top bit, with translation disabled and with the unit absent, separate the two bypass causes from the cache-inhibit rule.

Misses, cleared valid bits, duplicate tags and revoked permissions in each privilege mode separate the miss, priority and fault paths. Reading back tag words after each lookup and probe exposes wrong LRU arithmetic or stray updates. Lookups issued in the same cycle as a table write show the old-contents rule and the rule that a write overrides the LRU update.

// File: rtl/insn_tlb_pkg.sv
package insn_tlb_pkg;
  typedef struct packed {
    logic capture;
    logic lruUpdate;
    logic respond;
  } tlbStrobe_t;

  typedef enum logic {ST_IDLE, ST_WAIT} tlbState_t;
endpackage

// File: rtl/insn_tlb_match.sv
module insn_tlb_match #(
  parameter int ADDR_W    = 32,
  parameter int WAYS      = 2,
  parameter int PAGE_LOG2 = 13,
  parameter int SET_W     = 4,
  parameter int WAY_W     = 1
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        superMode,
  input  logic [WAYS-1:0][ADDR_W-1:0] matchSet,
  input  logic [WAYS-1:0][ADDR_W-1:0] transSet,
  output logic                        hit,
  output logic [WAY_W-1:0]            hitWay,
  output logic [ADDR_W-1:0]           paddr,
  output logic                        ci,
  output logic                        permOk
);
  localparam logic [ADDR_W-1:0] OFF_MASK = (ADDR_W'(1) << PAGE_LOG2) - ADDR_W'(1);
  localparam logic [ADDR_W-1:0] VPN_MASK = ~((ADDR_W'(1) << (PAGE_LOG2 + SET_W)) - ADDR_W'(1));

  logic [ADDR_W-1:0] selTrans;

  // descending scan: the last assignment is the lowest matching way
  always_comb begin
    hit    = 1'b0;
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (matchSet[w][0] && (((matchSet[w] ^ addr) & VPN_MASK) == '0)) begin
        hit    = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
  end

  assign selTrans = transSet[hitWay];
  assign paddr    = (selTrans & ~OFF_MASK) | (addr & OFF_MASK);
  assign ci       = selTrans[0];
  assign permOk   = superMode ? selTrans[1] : selTrans[2];
endmodule

// File: rtl/insn_tlb_ctrl.sv
module insn_tlb_ctrl
  import insn_tlb_pkg::*;
#(
  parameter int HIT_LAT  = 2,
  parameter int MISS_LAT = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lookHit,
  input  logic       lookBypass,
  output tlbStrobe_t strobe,
  output logic       reqReady,
  output logic       rspValid
);
  localparam int MAX_LAT = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
  localparam int CNT_W   = (MAX_LAT > 0) ? $clog2(MAX_LAT + 1) : 1;

  tlbState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] latNext;

  always_comb begin
    strobe.capture   = reqValid && (state == ST_IDLE);
    strobe.lruUpdate = strobe.capture && lookHit;
    strobe.respond   = (state == ST_WAIT) && (cnt == '0);
    if (lookBypass)   latNext = '0;
    else if (lookHit) latNext = CNT_W'(HIT_LAT);
    else              latNext = CNT_W'(MISS_LAT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (strobe.capture) begin
      state <= ST_WAIT;
      cnt   <= latNext;
    end else if (state == ST_WAIT) begin
      if (cnt == '0) state <= ST_IDLE;
      else           cnt   <= cnt - CNT_W'(1);
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = strobe.respond;
endmodule

// File: rtl/insn_tlb_datapath.sv
module insn_tlb_datapath
  import insn_tlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SETS      = 16,
  parameter int WAYS      = 2,
  parameter int PAGE_LOG2 = 13,
  parameter int LRU_W     = 2,
  parameter int SET_W     = $clog2(SETS),
  parameter int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tlbStrobe_t               strobe,
  input  logic                     xlateEn,
  input  logic                     present,
  input  logic                     superMode,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [ADDR_W-1:0]        probeAddr,
  input  logic                     cfgWe,
  input  logic [SET_W+WAY_W:0]     cfgAddr,
  input  logic [ADDR_W-1:0]        cfgWdata,
  output logic [ADDR_W-1:0]        cfgRdata,
  output logic [ADDR_W-1:0]        probePaddr,
  output logic                     lookHit,
  output logic                     lookBypass,
  output logic [ADDR_W-1:0]        rspAddr,
  output logic                     rspCi,
  output logic                     rspHit,
  output logic                     rspMiss,
  output logic                     rspFault
);
  localparam int               LRU_LSB    = 6;
  localparam logic [LRU_W-1:0] LRU_RELOAD = LRU_W'(SETS - 1);

  logic [ADDR_W-1:0] matchMem [WAYS][SETS];
  logic [ADDR_W-1:0] transMem [WAYS][SETS];

  logic [SET_W-1:0] reqSet, prbSet, regSet;
  logic [WAY_W-1:0] regWay;
  logic             regSel, active;

  logic [WAYS-1:0][ADDR_W-1:0] reqMatch, reqTrans, prbMatch, prbTrans;
  logic [LRU_W-1:0]            lruNext [WAYS];

  logic              reqHit, reqCi, reqPerm;
  logic [WAY_W-1:0]  reqHitWay;
  logic [ADDR_W-1:0] reqPaddr;
  logic              prbHit, prbCi, prbPerm;
  logic [WAY_W-1:0]  prbHitWay;
  logic [ADDR_W-1:0] prbPaddr;
  logic              unusedPrb;

  assign reqSet = reqAddr[PAGE_LOG2 +: SET_W];
  assign prbSet = probeAddr[PAGE_LOG2 +: SET_W];
  assign regSel = cfgAddr[SET_W+WAY_W];
  assign regWay = cfgAddr[SET_W +: WAY_W];
  assign regSet = cfgAddr[SET_W-1:0];
  assign active = xlateEn & present;

  for (genvar g = 0; g < WAYS; g++) begin : gWay
    assign reqMatch[g] = matchMem[g][reqSet];
    assign reqTrans[g] = transMem[g][reqSet];
    assign prbMatch[g] = matchMem[g][prbSet];
    assign prbTrans[g] = transMem[g][prbSet];

    always_comb begin
      logic [LRU_W-1:0] cur;
      cur        = reqMatch[g][LRU_LSB +: LRU_W];
      lruNext[g] = (cur != '0) ? cur - LRU_W'(1) : cur;
      if (reqHitWay == WAY_W'(g)) lruNext[g] = lruNext[g] | LRU_RELOAD;
    end
  end

  insn_tlb_match #(.ADDR_W(ADDR_W), .WAYS(WAYS), .PAGE_LOG2(PAGE_LOG2),
                   .SET_W(SET_W), .WAY_W(WAY_W)) uReq (
    .addr(reqAddr), .superMode(superMode), .matchSet(reqMatch), .transSet(reqTrans),
    .hit(reqHit), .hitWay(reqHitWay), .paddr(reqPaddr), .ci(reqCi), .permOk(reqPerm));

  insn_tlb_match #(.ADDR_W(ADDR_W), .WAYS(WAYS), .PAGE_LOG2(PAGE_LOG2),
                   .SET_W(SET_W), .WAY_W(WAY_W)) uPrb (
    .addr(probeAddr), .superMode(superMode), .matchSet(prbMatch), .transSet(prbTrans),
    .hit(prbHit), .hitWay(prbHitWay), .paddr(prbPaddr), .ci(prbCi), .permOk(prbPerm));

  assign unusedPrb  = prbCi ^ (^prbHitWay);
  assign lookHit    = active & reqHit;
  assign lookBypass = ~active;
  assign probePaddr = !active ? probeAddr : ((prbHit && prbPerm) ? prbPaddr : '0);
  assign cfgRdata   = regSel ? transMem[regWay][regSet] : matchMem[regWay][regSet];

  // table storage: LRU update first, register write last so it wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          matchMem[w][s] <= '0;
          transMem[w][s] <= '0;
        end
    end else begin
      if (strobe.lruUpdate)
        for (int w = 0; w < WAYS; w++)
          matchMem[w][reqSet][LRU_LSB +: LRU_W] <= lruNext[w];
      if (cfgWe) begin
        if (regSel) transMem[regWay][regSet] <= cfgWdata;
        else        matchMem[regWay][regSet] <= cfgWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspAddr  <= '0;
      rspCi    <= 1'b0;
      rspHit   <= 1'b0;
      rspMiss  <= 1'b0;
      rspFault <= 1'b0;
    end else if (strobe.capture) begin
      if (!active) begin
        rspAddr  <= reqAddr;
        rspCi    <= reqAddr[ADDR_W-1];
        rspHit   <= 1'b0;
        rspMiss  <= 1'b0;
        rspFault <= 1'b0;
      end else if (reqHit) begin
        rspAddr  <= reqPaddr;
        rspCi    <= reqCi;
        rspHit   <= 1'b1;
        rspMiss  <= 1'b0;
        rspFault <= ~reqPerm;
      end else begin
        rspAddr  <= '0;
        rspCi    <= 1'b0;
        rspHit   <= 1'b0;
        rspMiss  <= 1'b1;
        rspFault <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/insn_tlb.sv
module insn_tlb
  import insn_tlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SETS      = 16,
  parameter int WAYS      = 2,
  parameter int PAGE_LOG2 = 13,
  parameter int LRU_W     = 2,
  parameter int HIT_LAT   = 2,
  parameter int MISS_LAT  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     xlateEn,
  input  logic                     present,
  input  logic                     superMode,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [ADDR_W-1:0]        reqAddr,
  output logic                     rspValid,
  output logic [ADDR_W-1:0]        rspAddr,
  output logic                     rspCi,
  output logic                     rspHit,
  output logic                     rspMiss,
  output logic                     rspFault,
  input  logic [ADDR_W-1:0]        probeAddr,
  output logic [ADDR_W-1:0]        probePaddr,
  input  logic                     cfgWe,
  input  logic [$clog2(SETS)+((WAYS>1)?$clog2(WAYS):1):0] cfgAddr,
  input  logic [ADDR_W-1:0]        cfgWdata,
  output logic [ADDR_W-1:0]        cfgRdata,
  output logic [31:0]              cfgWord
);
  localparam int          SET_W    = $clog2(SETS);
  localparam int          WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [31:0] CFG_WORD = (32'(SET_W) << 3) | 32'(WAYS - 1);

  tlbStrobe_t strobe;
  logic       lookHit, lookBypass;

  insn_tlb_ctrl #(.HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .lookHit(lookHit),
    .lookBypass(lookBypass), .strobe(strobe), .reqReady(reqReady), .rspValid(rspValid));

  insn_tlb_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .PAGE_LOG2(PAGE_LOG2),
                      .LRU_W(LRU_W), .SET_W(SET_W), .WAY_W(WAY_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .xlateEn(xlateEn), .present(present),
    .superMode(superMode), .reqAddr(reqAddr), .probeAddr(probeAddr), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .probePaddr(probePaddr),
    .lookHit(lookHit), .lookBypass(lookBypass), .rspAddr(rspAddr), .rspCi(rspCi),
    .rspHit(rspHit), .rspMiss(rspMiss), .rspFault(rspFault));

  assign cfgWord = CFG_WORD;
endmodule

// File: rtl/insn_tlb_checker.sv
module insn_tlb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              xlateEn,
  input logic              present,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              rspCi,
  input logic              rspHit,
  input logic              rspMiss,
  input logic              rspFault,
  input logic [ADDR_W-1:0] probeAddr,
  input logic [ADDR_W-1:0] probePaddr
);
  assert_bypass_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(xlateEn && present)) |=>
      (rspValid && rspAddr == $past(reqAddr) && rspCi == $past(reqAddr[ADDR_W-1])
       && !rspHit && !rspMiss && !rspFault));

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> (rspAddr == '0 && !rspCi && !rspHit && !rspFault));

  assert_fault_on_hit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> rspHit);

  assert_probe_bypass_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(xlateEn && present) |-> (probePaddr == probeAddr));

  assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_rsp_not_ready_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  assert_rsp_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady));
endmodule

bind insn_tlb insn_tlb_checker #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/sim_insn_tlb.sv
`timescale 1ns/1ps
module sim_insn_tlb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xlateEn = 1'b0, present = 1'b1, superMode = 1'b1;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid, rspCi, rspHit, rspMiss, rspFault;
  logic [31:0] rspAddr;
  logic [31:0] probeAddr = '0;
  logic [31:0] probePaddr;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [31:0] cfgWord;

  int total = 0;
  int bad = 0;

  logic [31:0] mM [2][4];
  logic [31:0] mT [2][4];

  always #2.5 clk = ~clk;

  insn_tlb #(.ADDR_W(32), .SETS(4), .WAYS(2), .PAGE_LOG2(12), .LRU_W(2),
             .HIT_LAT(2), .MISS_LAT(5)) u0 (
    .clk(clk), .rstN(rstN), .xlateEn(xlateEn), .present(present), .superMode(superMode),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspAddr(rspAddr), .rspCi(rspCi), .rspHit(rspHit), .rspMiss(rspMiss),
    .rspFault(rspFault), .probeAddr(probeAddr), .probePaddr(probePaddr), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .cfgWord(cfgWord));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input bit sel, input int way, input int set, input logic [31:0] d);
    @(negedge clk);
    cfgWe    = 1'b1;
    cfgAddr  = {sel, way[0], set[1:0]};
    cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (sel) mT[way][set] = d; else mM[way][set] = d;
  endtask

  task automatic regRead(input bit sel, input int way, input int set, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = {sel, way[0], set[1:0]};
    #1;
    d = cfgRdata;
  endtask

  function automatic int findWay(input logic [31:0] a);
    int s = int'((a >> 12) & 3);
    for (int w = 0; w < 2; w++)
      if (mM[w][s][0] && (((mM[w][s] ^ a) & 32'hFFFF_C000) == 0)) return w;
    return -1;
  endfunction

  function automatic logic [31:0] probeExp(input logic [31:0] a, input bit sup,
                                           input bit en, input bit pres);
    int s = int'((a >> 12) & 3);
    int hw;
    logic [31:0] t;
    if (!(en && pres)) return a;
    hw = findWay(a);
    if (hw < 0) return 32'h0;
    t = mT[hw][s];
    if (!(sup ? t[1] : t[2])) return 32'h0;
    return (t & 32'hFFFF_F000) | (a & 32'hFFF);
  endfunction

  task automatic doLookup(input string req, input logic [31:0] a, input bit sup,
                          input bit en, input bit pres, input bit doW, input bit wSel,
                          input int wWay, input int wSet, input logic [31:0] wData);
    int s = int'((a >> 12) & 3);
    int hw = -1;
    int elat, lat;
    logic [31:0] ea, t;
    logic eci, eh, em, ef;
    if (!(en && pres)) begin
      ea = a; eci = a[31]; eh = 0; em = 0; ef = 0; elat = 0;
    end else begin
      hw = findWay(a);
      if (hw >= 0) begin
        t = mT[hw][s];
        ea = (t & 32'hFFFF_F000) | (a & 32'hFFF);
        eci = t[0]; eh = 1; em = 0; ef = sup ? !t[1] : !t[2]; elat = 2;
      end else begin
        ea = 0; eci = 0; eh = 0; em = 1; ef = 0; elat = 5;
      end
    end
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    xlateEn = en; present = pres; superMode = sup;
    reqAddr = a; reqValid = 1'b1;
    if (doW) begin
      cfgWe = 1'b1; cfgAddr = {wSel, wWay[0], wSet[1:0]}; cfgWdata = wData;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b0;
    if (hw >= 0)
      for (int w = 0; w < 2; w++) begin
        logic [1:0] l = mM[w][s][7:6];
        if (l != 0) l = l - 1;
        if (w == hw) l = l | 2'b11;
        mM[w][s][7:6] = l;
      end
    if (doW) begin
      if (wSel) mT[wWay][wSet] = wData; else mM[wWay][wSet] = wData;
    end
    lat = 0;
    while (!rspValid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk(req, "latency", 32'(lat), 32'(elat));
    chk(req, "rspAddr", rspAddr, ea);
    chk(req, "rspCi", 32'(rspCi), 32'(eci));
    chk(req, "rspHit", 32'(rspHit), 32'(eh));
    chk(req, "rspMiss", 32'(rspMiss), 32'(em));
    chk(req, "rspFault", 32'(rspFault), 32'(ef));
    @(negedge clk);
    chk("R12", "ready after response", 32'(reqReady), 32'd1);
  endtask

  task automatic checkSet(input string req, input int s);
    logic [31:0] d;
    for (int w = 0; w < 2; w++) begin
      regRead(1'b0, w, s, d);
      chk(req, "tag word", d, mM[w][s]);
    end
  endtask

  task automatic doProbe(input string req, input logic [31:0] a, input bit sup,
                         input bit en, input bit pres);
    @(negedge clk);
    xlateEn = en; present = pres; superMode = sup; probeAddr = a;
    #1;
    chk(req, "probePaddr", probePaddr, probeExp(a, sup, en, pres));
  endtask

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL R12 watchdog expired: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) begin
        mM[w][s] = '0;
        mT[w][s] = '0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11", "reqReady", 32'(reqReady), 32'd1);
    chk("R11", "rspValid", 32'(rspValid), 32'd0);
    for (int w = 0; w < 2; w++)
      for (int s = 0; s < 4; s++) begin
        regRead(1'b0, w, s, d); chk("R11", "tag reset", d, 32'h0);
        regRead(1'b1, w, s, d); chk("R11", "trans reset", d, 32'h0);
      end
    chk("R9", "cfgWord", cfgWord, 32'h0000_0011);

    // passthrough on both bypass causes, either side of the top bit
    doLookup("R1", 32'h7FFF_F123, 1, 0, 1, 0, 0, 0, 0, 0);
    doLookup("R1", 32'h8000_0000, 1, 0, 1, 0, 0, 0, 0, 0);
    doLookup("R1", 32'hFFFF_FFFF, 0, 0, 1, 0, 0, 0, 0, 0);
    doLookup("R1", 32'h8000_1000, 1, 1, 0, 0, 0, 0, 0, 0);
    doLookup("R1", 32'h0001_0000, 1, 1, 0, 0, 0, 0, 0, 0);

    // fill: way w of set s holds page (w+1)<<16; CI on way 1; UXE off in set 3
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin
        regWrite(1'b0, w, s, (32'(w + 1) << 16) | 32'h1);
        regWrite(1'b1, w, s, (32'(32'h100 + s * 4 + w) << 12) | 32'(w == 1) | 32'h2
                             | (32'(s != 3) << 2));
      end
    regRead(1'b1, 1, 2, d);
    chk("R10", "trans readback", d, mT[1][2]);
    regRead(1'b0, 0, 3, d);
    chk("R10", "tag readback", d, mM[0][3]);

    // hit sweep over all entries and offset extremes (R2 R3 R6)
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 3; k++) begin
          logic [31:0] off = (k == 0) ? 32'h000 : (k == 1) ? 32'hABC : 32'hFFF;
          doLookup("R3", (32'(w + 1) << 16) | (32'(s) << 12) | off, 1, 1, 1, 0, 0, 0, 0, 0);
          checkSet("R6", s);
        end

    // miss leaves every entry unchanged
    doLookup("R4", 32'h0007_1234, 1, 1, 1, 0, 0, 0, 0, 0);
    checkSet("R4", 1);

    // permissions per privilege mode
    doLookup("R5", 32'h0001_3010, 0, 1, 1, 0, 0, 0, 0, 0);
    checkSet("R6", 3);
    regWrite(1'b1, 0, 2, (32'h222 << 12) | 32'h4);
    doLookup("R5", 32'h0001_2020, 1, 1, 1, 0, 0, 0, 0, 0);
    doLookup("R5", 32'h0001_2020, 0, 1, 1, 0, 0, 0, 0, 0);

    // cleared valid bit
    regWrite(1'b0, 1, 0, 32'h0002_0000);
    doLookup("R2", 32'h0002_0040, 1, 1, 1, 0, 0, 0, 0, 0);

    // duplicate tags: lowest way wins
    regWrite(1'b0, 1, 1, 32'h0001_0001);
    doLookup("R7", 32'h0001_1555, 1, 1, 1, 0, 0, 0, 0, 0);
    checkSet("R7", 1);

    // probe port: hit, denied, miss, bypass, then no state change
    doProbe("R8", 32'h0001_0345, 1, 1, 1);
    doProbe("R8", 32'h0001_2345, 1, 1, 1);
    doProbe("R8", 32'h0001_2345, 0, 1, 1);
    doProbe("R8", 32'h0007_0000, 1, 1, 1);
    doProbe("R8", 32'h8123_4567, 1, 0, 1);
    checkSet("R8", 0);
    checkSet("R8", 2);

    // write in the lookup cycle: old contents seen, new contents next time
    doLookup("R10", 32'h0001_0010, 1, 1, 1, 1, 1, 0, 0, (32'h3AB << 12) | 32'h2);
    doLookup("R10", 32'h0001_0010, 1, 1, 1, 0, 0, 0, 0, 0);
    // tag write on the same edge as a hit on that tag overrides the LRU update
    doLookup("R10", 32'h0001_0020, 1, 1, 1, 1, 0, 0, 0, 32'h0001_0041);
    checkSet("R10", 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule